// File: doc/BRIEF.md
# Maskable Interrupt Controller

This block gathers a set of level-sensitive interrupt requests for a single processor and drives one interrupt line to it. Hardware sources enter on a parallel input bus. The lowest source position is taken by a flag that software sets and clears itself, so software can interrupt its own processor. The block holds one enable bit per source position. Software reads back either the unfiltered request levels or the levels after they pass through the enable bits.

Software never writes the enable register directly. It has one location that turns enable bits on and another that turns them off, and each acts only on the bits written as 1. Two concurrent software tasks can therefore each change their own bits without a read-modify-write race. The register port is a simple synchronous bus: address, write strobe, write data and a registered read result.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While rst_n is low at a clock edge, the enable bits and the software flag clear to zero. After that edge, irq_o and rdata_o are zero.
- R2: A read of offset 0x4 shows the raw levels: bit 0 is the software flag and bits 21..1 are hw_irq_i[20..0], as sampled in the cycle the address is presented. rdata_o carries the result one cycle later, and bits 31..22 of rdata_o are always zero.
- R3: A read of offset 0x0 returns the raw levels ANDed bit by bit with the enable bits, with the same one-cycle latency.
- R4: A write to offset 0x8 sets every enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R5: A write to offset 0xC clears every enable bit whose write-data bit is 1 and leaves the bits written as 0 unchanged.
- R6: A read of offset 0x8 returns the enable bits as they stood before the edge that captures the read.
- R7: Writing 1 in data bit 0 to offset 0x10 sets the software flag. Writing 1 in data bit 0 to offset 0x14 clears it. A write with data bit 0 at 0 to either offset leaves the flag unchanged.
- R8: irq_o is a register. After each edge it holds the OR of raw AND enable as that value stood before the edge.
- R9: Writes to offsets 0x0, 0x4 and to unmapped offsets leave the enable bits and the software flag unchanged, as do write-data bits 31..22. Reads of 0xC, 0x10, 0x14 and unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_irq_i | input | 21 | Hardware request levels; bit n lands at source bit n+1 (counter/timers at source bits 5, 6, 7) |
| addr_i | input | 5 | Register byte offset |
| wr_en_i | input | 1 | Write strobe for the current address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read result for the address presented in the previous cycle |
| irq_o | output | 1 | Registered processor interrupt request |

## Verification
The hardest case to reach from the ports is a write of 0 bits that must leave enable bits alone while the same write changes other bits. Only a readback of offset 0x8, or a masked status read, can show whether a stray enable bit changed. The stimulus first sets a patchwork enable pattern. It then sends partial set and clear writes with interleaved zeros and reads the enable register back after each one. The same sequence runs with the software flag toggling under held hardware levels. A reference model compares rdata_o and irq_o on every clock.

// File: rtl/irqc_pkg.sv
// Package irqc_pkg: shared sizes and register offsets for the interrupt controller.
// Assumes NSRC does not exceed DATA_W.
package irqc_pkg;
    localparam int unsigned NSRC   = 22;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    localparam int unsigned OFS_STATUS = 'h00;
    localparam int unsigned OFS_RAW    = 'h04;
    localparam int unsigned OFS_ENSET  = 'h08;
    localparam int unsigned OFS_ENCLR  = 'h0C;
    localparam int unsigned OFS_SWSET  = 'h10;
    localparam int unsigned OFS_SWCLR  = 'h14;
endpackage

// File: rtl/irqc_enable_reg.sv
// Module irqc_enable_reg: holds the enable bits and the software request flag.
// Only the set/clear strobe locations change state. Assumes the address decoding is exact.
module irqc_enable_reg
    import irqc_pkg::*;
#(
    parameter int unsigned N  = NSRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [N-1:0]  en_q,
    output logic          sw_q
);
    localparam logic [AW-1:0] A_SET   = OFS_ENSET[AW-1:0];
    localparam logic [AW-1:0] A_CLR   = OFS_ENCLR[AW-1:0];
    localparam logic [AW-1:0] A_SWSET = OFS_SWSET[AW-1:0];
    localparam logic [AW-1:0] A_SWCLR = OFS_SWCLR[AW-1:0];

    logic [N-1:0] wbits;
    assign wbits = wdata_i[N-1:0];

    // Enable register: set on 1s at the set location, clear on 1s at the clear location.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_q <= '0;
        else if (wr_en_i && addr_i == A_SET)
            en_q <= en_q | wbits;
        else if (wr_en_i && addr_i == A_CLR)
            en_q <= en_q & ~wbits;
    end

    // Software flag: set or clear from data bit 0 at its own two locations.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sw_q <= 1'b0;
        else if (wr_en_i && addr_i == A_SWSET && wdata_i[0])
            sw_q <= 1'b1;
        else if (wr_en_i && addr_i == A_SWCLR && wdata_i[0])
            sw_q <= 1'b0;
    end
endmodule

// File: rtl/irqc_line.sv
// Module irqc_line: builds raw and masked source vectors and registers the OR as the request line.
// Assumes the hardware inputs are already synchronous to clk.
module irqc_line
    import irqc_pkg::*;
#(
    parameter int unsigned N = NSRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-2:0] hw_irq_i,
    input  logic         sw_q,
    input  logic [N-1:0] en_q,
    output logic [N-1:0] raw,
    output logic [N-1:0] masked,
    output logic         irq_o
);
    // Raw vector: software flag at bit 0, hardware levels above it.
    always_comb raw = {hw_irq_i, sw_q};

    // Masked vector: raw filtered by the enable bits.
    always_comb masked = raw & en_q;

    // Request line register: one cycle behind the masked OR.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= |masked;
    end
endmodule

// File: rtl/irqc_read_port.sv
// Module irqc_read_port: registered read multiplexer. Write-only and unmapped offsets return zero.
// Assumes N <= DW.
module irqc_read_port
    import irqc_pkg::*;
#(
    parameter int unsigned N  = NSRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr_i,
    input  logic [N-1:0]  raw,
    input  logic [N-1:0]  masked,
    input  logic [N-1:0]  en_q,
    output logic [DW-1:0] rdata_o
);
    localparam logic [AW-1:0] A_STAT = OFS_STATUS[AW-1:0];
    localparam logic [AW-1:0] A_RAW  = OFS_RAW[AW-1:0];
    localparam logic [AW-1:0] A_EN   = OFS_ENSET[AW-1:0];

    logic [N-1:0] sel;

    // Source selection by offset.
    always_comb begin
        case (addr_i)
            A_STAT:  sel = masked;
            A_RAW:   sel = raw;
            A_EN:    sel = en_q;
            default: sel = '0;
        endcase
    end

    // Read data register, zero-extended to the bus width.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= DW'(sel);
    end
endmodule

// File: rtl/irq_mask_ctrl.sv
// Module irq_mask_ctrl: per-processor maskable interrupt controller (top).
// Assumes a synchronous bus with one access per cycle and synchronous active-low reset.
module irq_mask_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned N  = NSRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-2:0]  hw_irq_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    logic [N-1:0] en_q;
    logic         sw_q;
    logic [N-1:0] raw;
    logic [N-1:0] masked;

    irqc_enable_reg #(.N(N), .AW(AW), .DW(DW)) u_en (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
        .wdata_i(wdata_i), .en_q(en_q), .sw_q(sw_q)
    );

    irqc_line #(.N(N)) u_line (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i), .sw_q(sw_q),
        .en_q(en_q), .raw(raw), .masked(masked), .irq_o(irq_o)
    );

    irqc_read_port #(.N(N), .AW(AW), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .raw(raw),
        .masked(masked), .en_q(en_q), .rdata_o(rdata_o)
    );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
// Module irq_mask_ctrl_chk: temporal properties of the controller, bound to the top.
module irq_mask_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int unsigned N  = NSRC,
    parameter int unsigned AW = ADDR_W,
    parameter int unsigned DW = DATA_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wdata_i,
    input logic [DW-1:0] rdata_o,
    input logic          irq_o,
    input logic [N-1:0]  en_q,
    input logic          sw_q,
    input logic [N-1:0]  masked
);
    logic set_wr, clr_wr, sws_wr, swc_wr;
    assign set_wr = wr_en_i && addr_i == OFS_ENSET[AW-1:0];
    assign clr_wr = wr_en_i && addr_i == OFS_ENCLR[AW-1:0];
    assign sws_wr = wr_en_i && addr_i == OFS_SWSET[AW-1:0] && wdata_i[0];
    assign swc_wr = wr_en_i && addr_i == OFS_SWCLR[AW-1:0] && wdata_i[0];

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (en_q == '0 && !sw_q && !irq_o && rdata_o == '0));

    assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DW-1:N] == '0);

    assert_set_bits_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en_q & $past(wdata_i[N-1:0])) == $past(wdata_i[N-1:0])));

    assert_set_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        set_wr |=> ((en_q & ~$past(wdata_i[N-1:0])) == ($past(en_q) & ~$past(wdata_i[N-1:0]))));

    assert_clr_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> ((en_q & $past(wdata_i[N-1:0])) == '0));

    assert_sw_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sws_wr |=> sw_q);

    assert_sw_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        swc_wr |=> !sw_q);

    assert_irq_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (masked != '0) |=> irq_o);

    assert_en_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_wr || clr_wr) |=> $stable(en_q));
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.N(N), .AW(AW), .DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .en_q(en_q), .sw_q(sw_q), .masked(masked)
);

// File: tb/test_irq_mask_ctrl.sv
// Bench test_irq_mask_ctrl: behavioural reference model compared on every clock.
module test_irq_mask_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [20:0] hw_irq_i = '0;
    logic [4:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    // Model state
    int unsigned m_en = 0;
    int unsigned m_sw = 0;
    int unsigned exp_rd = 0;
    bit          exp_irq = 0;
    string       cur_tag = "R1";

    always #4 clk = ~clk; // 125 MHz

    irq_mask_ctrl i_irq_mask_ctrl (
        .clk(clk), .rst_n(rst_n), .hw_irq_i(hw_irq_i), .addr_i(addr_i),
        .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(string tag, int unsigned act, int unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One bus cycle: check outputs due from the previous cycle, then drive and predict.
    task automatic step(string tag, int a, bit we, int unsigned d, int unsigned hw);
        int unsigned raw;
        @(negedge clk);
        check({cur_tag, " rdata"}, rdata_o, exp_rd);
        check({cur_tag, " irq"}, 32'(irq_o), 32'(exp_irq));
        addr_i = 5'(a); wr_en_i = we; wdata_i = d; hw_irq_i = 21'(hw);
        raw = ((hw & 32'h1F_FFFF) << 1) | m_sw;
        case (a)
            'h00: exp_rd = raw & m_en;
            'h04: exp_rd = raw;
            'h08: exp_rd = m_en;
            default: exp_rd = 0;
        endcase
        exp_irq = ((raw & m_en) != 0);
        if (we) begin
            if (a == 'h08) m_en = m_en | (d & 32'h3F_FFFF);
            if (a == 'h0C) m_en = m_en & ~d;
            if (a == 'h10 && d[0]) m_sw = 1;
            if (a == 'h14 && d[0]) m_sw = 0;
        end
        cur_tag = tag;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 rdata reset", rdata_o, 0);
        check("R1 irq reset", 32'(irq_o), 0);
        rst_n = 1'b1;
        cur_tag = "R1";
        step("R1 en after reset", 'h08, 0, 0, 0);
        step("R2 raw idle", 'h04, 0, 0, 'h0F0F0F);
        step("R2 raw ones", 'h04, 0, 0, 'h1FFFFF);
        step("R3 status masked off", 'h00, 0, 0, 'h1FFFFF);
        // R4 partial sets; timer bits 5,6,7 map from hw 4,5,6
        step("R4 set timers", 'h08, 1, 32'h0000_00E0, 'h000070);
        step("R6 read en", 'h08, 0, 0, 'h000070);
        step("R4 set more", 'h08, 1, 32'h0030_0402, 'h000070);
        step("R4 zero write keeps", 'h08, 1, 0, 0);
        step("R6 read en", 'h08, 0, 0, 0);
        step("R3 status", 'h00, 0, 0, 'h1FFFFF);
        step("R8 irq timers", 'h00, 0, 0, 'h000020);
        step("R5 clear some", 'h0C, 1, 32'h0000_0042, 'h000020);
        step("R6 read en", 'h08, 0, 0, 'h000020);
        step("R5 zero clear keeps", 'h0C, 1, 0, 0);
        step("R6 read en", 'h08, 0, 0, 0);
        step("R9 write ro status", 'h00, 1, 32'hFFFF_FFFF, 0);
        step("R9 write ro raw", 'h04, 1, 32'hFFFF_FFFF, 0);
        step("R9 write unmapped", 'h1C, 1, 32'hFFFF_FFFF, 0);
        step("R9 read en", 'h08, 0, 0, 0);
        step("R9 read wo clr", 'h0C, 0, 0, 'h1FFFFF);
        step("R9 read wo swset", 'h10, 0, 0, 'h1FFFFF);
        step("R9 read wo swclr", 'h14, 0, 0, 'h1FFFFF);
        step("R9 read unmapped", 'h18, 0, 0, 'h1FFFFF);
        step("R4 high bits ignored", 'h08, 1, 32'hFFC0_0000, 0);
        step("R9 read en", 'h08, 0, 0, 0);
        step("R7 sw set bit0=0 no-op", 'h10, 1, 32'h0000_0002, 0);
        step("R7 raw sw", 'h04, 0, 0, 0);
        step("R7 sw set", 'h10, 1, 1, 0);
        step("R7 raw sw", 'h04, 0, 0, 0);
        step("R8 sw masked", 'h00, 0, 0, 0);
        step("R4 enable sw", 'h08, 1, 1, 0);
        step("R8 sw irq", 'h00, 0, 0, 0);
        step("R8 sw irq hold", 'h00, 0, 0, 'h1FFFFF);
        step("R7 sw clr bit0=0 no-op", 'h14, 1, 32'h0000_0004, 0);
        step("R7 sw clr", 'h14, 1, 1, 0);
        step("R7 raw after clr", 'h04, 0, 0, 0);
        step("R8 irq drop", 'h00, 0, 0, 0);
        step("R5 clear all", 'h0C, 1, 32'hFFFF_FFFF, 'h1FFFFF);
        step("R6 read en", 'h08, 0, 0, 'h1FFFFF);
        step("R8 all masked", 'h00, 0, 0, 'h1FFFFF);
        for (int i = 0; i < 40; i++) begin
            int unsigned pat;
            pat = (i * 32'h9E37_79B9) ^ (i << 7);
            step("R3 mixed", (i % 4) * 4, (i % 3) == 2, pat, pat >> 5);
        end
        step("R8 final", 'h00, 0, 0, 0);
        rst_n = 1'b0;
        m_en = 0; m_sw = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1 rdata re-reset", rdata_o, 0);
        check("R1 irq re-reset", 32'(irq_o), 0);
        rst_n = 1'b1;
        exp_rd = 0; exp_irq = 0; cur_tag = "R1";
        step("R1 en cleared", 'h08, 0, 0, 0);
        step("R1 sw cleared", 'h04, 0, 0, 0);
        step("R1 end", 'h00, 0, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule